// File: doc/BRIEF.md
# Host Pipe Bank and Configuration Manager

This block keeps the per-pipe state of a small set of host-side pipes (seven by default). For every pipe it stores an enable flag, a configuration word, a data-toggle bit, a two-bank byte buffer with its fill level, read pointer and current-bank flag, and two sticky error flags. A processor reaches all of it through a compact register window. It first writes a pipe number into a select register. Every later access to the window then targets that pipe, and a single data-port register pushes bytes into or pulls bytes out of the pipe's current bank.

Two reset levels exist beside the chip reset. A per-pipe reset mask returns the chosen pipes' buffer and error state to idle and keeps their configuration, toggle and enable. A global bus-reset pulse, or taking a pipe from enabled to disabled, wipes the pipe back to its power-on state. Scheduling of transactions and the serial line engine sit outside this block.

Top module: `pipe_bank_mgr`

## Requirements
- R1: After `rst_n` is released, the select register reads 0. Every pipe reads as disabled, with configuration 0, toggle 0, fill 0 and status 0.
- R2: The window decodes `cpu_addr` as follows: 0 pipe select, 1 data port, 2 enable (bit 0), 3 configuration, 4 toggle (bit 0), 5 bank release (write only, reads 0), 6 status, 7 fill count. A read sampled at a clock edge places its value on `cpu_rdata` after that edge, and `cpu_rdata` holds it until the next read. A write takes priority over a read in the same cycle.
- R3: On an enabled pipe, each data-port write stores the byte at the current fill position of the current bank and raises the fill by one. Each data-port read returns the byte at the read pointer and advances the pointer, so bytes come back in the order they were written.
- R4: A data-port write when the fill equals `BANK_DEPTH` is dropped, leaves the fill and the stored bytes unchanged, and sets status bit 0 (overflow).
- R5: A data-port read when the read pointer equals the fill returns 0, leaves the pointer unchanged and sets status bit 1 (underflow).
- R6: A bank-release write on an enabled pipe toggles status bit 2 (current bank) and sets the fill and the read pointer to 0. The error bits are kept.
- R7: A set bit in `pipe_rst_mask` clears that pipe's fill, read pointer, current bank and error bits. Its enable, configuration and toggle stay unchanged.
- R8: In the cycle in which a pipe's mask bit is set, every processor access to that pipe is dropped, and a data read then returns 0. Accesses to a pipe whose mask bit is clear are unaffected.
- R9: Writing enable 0 to an enabled pipe clears its configuration, toggle, buffer and error state. The pipe reads as in R1 when it is enabled again.
- R10: A `bus_rst` pulse returns every pipe to the R1 state and overrides any concurrent access. The select register keeps its value.
- R11: On a disabled pipe, data-port writes, data-port reads and bank releases change nothing. Data reads return 0.
- R12: A select value of `NUM_PIPES` or above selects no pipe. Writes to registers 1 to 7 then change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 3 | Register index within the window |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Registered read data |
| pipe_rst_mask | input | NUM_PIPES | Per-pipe partial reset, one bit per pipe |
| bus_rst | input | 1 | Global full reset pulse for all pipes |

## Verification
Two things can land on the same pipe in the same cycle: a partial reset through the mask, and a processor data write, data read or bank release aimed at that pipe. The bench raises the mask bit on the same falling edge that drives the data-port strobe. It then reads back the fill and status, and expects the access to have vanished and the configuration to have survived. It repeats the case with the mask on a different pipe, where the write must take effect normally.

// File: rtl/pbm_pkg.sv
// Package: shared register indices and the per-pipe operation bundle.
// Assumes a 3-bit register index inside the processor window.
package pbm_pkg;

    localparam logic [2:0] RA_PSEL = 3'd0;
    localparam logic [2:0] RA_DATA = 3'd1;
    localparam logic [2:0] RA_EN   = 3'd2;
    localparam logic [2:0] RA_CFG  = 3'd3;
    localparam logic [2:0] RA_TOG  = 3'd4;
    localparam logic [2:0] RA_REL  = 3'd5;
    localparam logic [2:0] RA_STAT = 3'd6;
    localparam logic [2:0] RA_FILL = 3'd7;

    // One decoded processor operation, broadcast to all pipes.
    typedef struct packed {
        logic wr_en;
        logic wr_cfg;
        logic wr_tog;
        logic wr_data;
        logic rd_data;
        logic release_bank;
    } pipe_op_t;

endpackage

// File: rtl/pbm_decode.sv
// Module: pbm_decode
// Turns the processor strobes and the select register into one operation
// bundle plus a one-hot pipe select. A write masks a concurrent read.
// Assumes SEL_W is wide enough to hold NUM_PIPES.
module pbm_decode #(
    parameter int NUM_PIPES = 7,
    parameter int SEL_W     = 3
) (
    input  logic                  cpu_wr,
    input  logic                  cpu_rd,
    input  logic [2:0]            cpu_addr,
    input  logic [SEL_W-1:0]      psel,
    output pbm_pkg::pipe_op_t     op,
    output logic [NUM_PIPES-1:0]  sel_vec,
    output logic                  rd_eff
);
    import pbm_pkg::*;

    // Purpose: classify the access by register index.
    always_comb begin
        rd_eff          = cpu_rd && !cpu_wr;
        op.wr_en        = cpu_wr && (cpu_addr == RA_EN);
        op.wr_cfg       = cpu_wr && (cpu_addr == RA_CFG);
        op.wr_tog       = cpu_wr && (cpu_addr == RA_TOG);
        op.wr_data      = cpu_wr && (cpu_addr == RA_DATA);
        op.release_bank = cpu_wr && (cpu_addr == RA_REL);
        op.rd_data      = rd_eff && (cpu_addr == RA_DATA);
    end

    // Purpose: one select line per implemented pipe; out-of-range selects none.
    for (genvar i = 0; i < NUM_PIPES; i++) begin : g_sel
        assign sel_vec[i] = (psel == SEL_W'(i));
    end

endmodule

// File: rtl/pbm_pipe.sv
// Module: pbm_pipe
// State of one pipe: enable, configuration, toggle, a two-bank byte buffer
// with fill/read pointer/current bank, and sticky overflow/underflow flags.
// Priority: bus reset, then partial reset, then processor access.
// Assumes BANK_DEPTH >= 2 and that one operation arrives per cycle.
module pbm_pipe #(
    parameter int DATA_W     = 8,
    parameter int CFG_W      = 8,
    parameter int BANK_DEPTH = 8,
    localparam int CNT_W     = $clog2(BANK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rst,
    input  logic               pipe_rst,
    input  logic               sel,
    input  pbm_pkg::pipe_op_t  op,
    input  logic [DATA_W-1:0]  wdata,
    output logic               en_o,
    output logic [CFG_W-1:0]   cfg_o,
    output logic               tog_o,
    output logic [CNT_W-1:0]   fill_o,
    output logic               bank_o,
    output logic               ovf_o,
    output logic               udf_o,
    output logic [DATA_W-1:0]  rd_byte_o
);
    localparam int               MEM_AW = $clog2(2 * BANK_DEPTH);
    localparam logic [CNT_W-1:0] FULL   = CNT_W'(BANK_DEPTH);

    logic              en_q, tog_q, bank_q, ovf_q, udf_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [CNT_W-1:0]  fill_q, rptr_q;
    logic [DATA_W-1:0] mem [2*BANK_DEPTH];
    logic              live, store;
    logic [MEM_AW-1:0] wr_slot, rd_slot;

    function automatic logic [MEM_AW-1:0] slot_of(input logic bank,
                                                  input logic [CNT_W-1:0] idx);
        return bank ? (MEM_AW'(BANK_DEPTH) + MEM_AW'(idx)) : MEM_AW'(idx);
    endfunction

    // Purpose: processor access reaches this pipe only when no reset claims it.
    always_comb begin
        live    = sel && !bus_rst && !pipe_rst;
        store   = live && en_q && op.wr_data && (fill_q != FULL);
        wr_slot = slot_of(bank_q, fill_q);
        rd_slot = slot_of(bank_q, rptr_q);
    end

    // Purpose: control and bank state with the two reset levels.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rst) begin
            en_q   <= 1'b0;
            cfg_q  <= '0;
            tog_q  <= 1'b0;
            fill_q <= '0;
            rptr_q <= '0;
            bank_q <= 1'b0;
            ovf_q  <= 1'b0;
            udf_q  <= 1'b0;
        end else if (pipe_rst) begin
            fill_q <= '0;
            rptr_q <= '0;
            bank_q <= 1'b0;
            ovf_q  <= 1'b0;
            udf_q  <= 1'b0;
        end else if (sel) begin
            if (op.wr_en) begin
                en_q <= wdata[0];
                if (en_q && !wdata[0]) begin
                    cfg_q  <= '0;
                    tog_q  <= 1'b0;
                    fill_q <= '0;
                    rptr_q <= '0;
                    bank_q <= 1'b0;
                    ovf_q  <= 1'b0;
                    udf_q  <= 1'b0;
                end
            end
            if (op.wr_cfg) cfg_q <= wdata[CFG_W-1:0];
            if (op.wr_tog) tog_q <= wdata[0];
            if (en_q && op.wr_data) begin
                if (fill_q == FULL) ovf_q  <= 1'b1;
                else                fill_q <= fill_q + 1'b1;
            end
            if (en_q && op.rd_data) begin
                if (rptr_q == fill_q) udf_q  <= 1'b1;
                else                  rptr_q <= rptr_q + 1'b1;
            end
            if (en_q && op.release_bank) begin
                bank_q <= !bank_q;
                fill_q <= '0;
                rptr_q <= '0;
            end
        end
    end

    // Purpose: buffer storage, no reset (contents are meaningless once freed).
    always_ff @(posedge clk) begin
        if (store) mem[wr_slot] <= wdata;
    end

    // Purpose: expose state; the byte under the read pointer, or 0 if none.
    always_comb begin
        en_o      = en_q;
        cfg_o     = cfg_q;
        tog_o     = tog_q;
        fill_o    = fill_q;
        bank_o    = bank_q;
        ovf_o     = ovf_q;
        udf_o     = udf_q;
        rd_byte_o = (en_q && (rptr_q != fill_q)) ? mem[rd_slot] : '0;
    end

endmodule

// File: rtl/pbm_rdmux.sv
// Module: pbm_rdmux
// Picks the selected pipe's fields and forms the next read value for the
// given register index. With no pipe selected, every pipe field reads 0.
// Assumes CFG_W and CNT_W do not exceed DATA_W.
module pbm_rdmux #(
    parameter int NUM_PIPES = 7,
    parameter int DATA_W    = 8,
    parameter int CFG_W     = 8,
    parameter int CNT_W     = 4,
    parameter int SEL_W     = 3
) (
    input  logic [2:0]                         cpu_addr,
    input  logic [SEL_W-1:0]                   psel,
    input  logic [NUM_PIPES-1:0]               sel_vec,
    input  logic                               kill,
    input  logic [NUM_PIPES-1:0]               en_a,
    input  logic [NUM_PIPES-1:0][CFG_W-1:0]    cfg_a,
    input  logic [NUM_PIPES-1:0]               tog_a,
    input  logic [NUM_PIPES-1:0][CNT_W-1:0]    fill_a,
    input  logic [NUM_PIPES-1:0]               bank_a,
    input  logic [NUM_PIPES-1:0]               ovf_a,
    input  logic [NUM_PIPES-1:0]               udf_a,
    input  logic [NUM_PIPES-1:0][DATA_W-1:0]   byte_a,
    output logic [DATA_W-1:0]                  rdata_nxt
);
    import pbm_pkg::*;

    logic              en_s, tog_s, bank_s, ovf_s, udf_s;
    logic [CFG_W-1:0]  cfg_s;
    logic [CNT_W-1:0]  fill_s;
    logic [DATA_W-1:0] byte_s;

    // Purpose: gather the selected pipe's fields through the one-hot select.
    always_comb begin
        en_s = 1'b0; tog_s = 1'b0; bank_s = 1'b0; ovf_s = 1'b0; udf_s = 1'b0;
        cfg_s = '0; fill_s = '0; byte_s = '0;
        for (int i = 0; i < NUM_PIPES; i++) begin
            if (sel_vec[i]) begin
                en_s   = en_a[i];
                tog_s  = tog_a[i];
                bank_s = bank_a[i];
                ovf_s  = ovf_a[i];
                udf_s  = udf_a[i];
                cfg_s  = cfg_a[i];
                fill_s = fill_a[i];
                byte_s = byte_a[i];
            end
        end
    end

    // Purpose: format the register value for the requested index.
    always_comb begin
        rdata_nxt = '0;
        case (cpu_addr)
            RA_PSEL: rdata_nxt = DATA_W'(psel);
            RA_DATA: rdata_nxt = kill ? '0 : byte_s;
            RA_EN:   rdata_nxt = DATA_W'(en_s);
            RA_CFG:  rdata_nxt = DATA_W'(cfg_s);
            RA_TOG:  rdata_nxt = DATA_W'(tog_s);
            RA_STAT: rdata_nxt = DATA_W'({bank_s, udf_s, ovf_s});
            RA_FILL: rdata_nxt = DATA_W'(fill_s);
            default: rdata_nxt = '0;
        endcase
    end

endmodule

// File: rtl/pipe_bank_mgr.sv
// Module: pipe_bank_mgr (top)
// Processor window onto NUM_PIPES host pipes: select register, decode,
// one pbm_pipe per pipe, and a registered read path.
// Assumes single-cycle strobes and a synchronous active-low reset.
module pipe_bank_mgr #(
    parameter int NUM_PIPES  = 7,
    parameter int DATA_W     = 8,
    parameter int CFG_W      = 8,
    parameter int BANK_DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_wr,
    input  logic                 cpu_rd,
    input  logic [2:0]           cpu_addr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    output logic [DATA_W-1:0]    cpu_rdata,
    input  logic [NUM_PIPES-1:0] pipe_rst_mask,
    input  logic                 bus_rst
);
    import pbm_pkg::*;

    localparam int SEL_W = $clog2(NUM_PIPES + 1);
    localparam int CNT_W = $clog2(BANK_DEPTH + 1);

    logic [SEL_W-1:0]                  psel_q;
    pipe_op_t                          op;
    logic [NUM_PIPES-1:0]              sel_vec;
    logic                              rd_eff, kill;
    logic [NUM_PIPES-1:0]              en_a, tog_a, bank_a, ovf_a, udf_a;
    logic [NUM_PIPES-1:0][CFG_W-1:0]   cfg_a;
    logic [NUM_PIPES-1:0][CNT_W-1:0]   fill_a;
    logic [NUM_PIPES-1:0][DATA_W-1:0]  byte_a;
    logic [DATA_W-1:0]                 rdata_nxt;

    // Purpose: pipe select register; survives a bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                               psel_q <= '0;
        else if (cpu_wr && (cpu_addr == RA_PSEL)) psel_q <= cpu_wdata[SEL_W-1:0];
    end

    pbm_decode #(.NUM_PIPES(NUM_PIPES), .SEL_W(SEL_W)) u_dec (
        .cpu_wr  (cpu_wr),
        .cpu_rd  (cpu_rd),
        .cpu_addr(cpu_addr),
        .psel    (psel_q),
        .op      (op),
        .sel_vec (sel_vec),
        .rd_eff  (rd_eff)
    );

    for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
        pbm_pipe #(.DATA_W(DATA_W), .CFG_W(CFG_W), .BANK_DEPTH(BANK_DEPTH)) u_pipe (
            .clk      (clk),
            .rst_n    (rst_n),
            .bus_rst  (bus_rst),
            .pipe_rst (pipe_rst_mask[i]),
            .sel      (sel_vec[i]),
            .op       (op),
            .wdata    (cpu_wdata),
            .en_o     (en_a[i]),
            .cfg_o    (cfg_a[i]),
            .tog_o    (tog_a[i]),
            .fill_o   (fill_a[i]),
            .bank_o   (bank_a[i]),
            .ovf_o    (ovf_a[i]),
            .udf_o    (udf_a[i]),
            .rd_byte_o(byte_a[i])
        );
    end

    // Purpose: a data read aimed at a pipe under reset yields nothing.
    assign kill = bus_rst || (|(sel_vec & pipe_rst_mask));

    pbm_rdmux #(
        .NUM_PIPES(NUM_PIPES), .DATA_W(DATA_W), .CFG_W(CFG_W),
        .CNT_W(CNT_W), .SEL_W(SEL_W)
    ) u_rdmux (
        .cpu_addr (cpu_addr),
        .psel     (psel_q),
        .sel_vec  (sel_vec),
        .kill     (kill),
        .en_a     (en_a),
        .cfg_a    (cfg_a),
        .tog_a    (tog_a),
        .fill_a   (fill_a),
        .bank_a   (bank_a),
        .ovf_a    (ovf_a),
        .udf_a    (udf_a),
        .byte_a   (byte_a),
        .rdata_nxt(rdata_nxt)
    );

    // Purpose: registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      cpu_rdata <= '0;
        else if (rd_eff) cpu_rdata <= rdata_nxt;
    end

endmodule

// File: rtl/pbm_chk.sv
// Module: pbm_chk
// Temporal checks on pipe_bank_mgr, attached by bind below.
module pbm_chk #(
    parameter int NUM_PIPES  = 7,
    parameter int DATA_W     = 8,
    parameter int CFG_W      = 8,
    parameter int BANK_DEPTH = 8,
    parameter int SEL_W      = 3,
    parameter int CNT_W      = 4
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               cpu_wr,
    input logic                               cpu_rd,
    input logic [2:0]                         cpu_addr,
    input logic [DATA_W-1:0]                  cpu_wdata,
    input logic [DATA_W-1:0]                  cpu_rdata,
    input logic [NUM_PIPES-1:0]               pipe_rst_mask,
    input logic                               bus_rst,
    input logic [SEL_W-1:0]                   psel,
    input logic [NUM_PIPES-1:0]               en_a,
    input logic [NUM_PIPES-1:0][CFG_W-1:0]    cfg_a,
    input logic [NUM_PIPES-1:0]               tog_a,
    input logic [NUM_PIPES-1:0][CNT_W-1:0]    fill_a,
    input logic [NUM_PIPES-1:0]               bank_a,
    input logic [NUM_PIPES-1:0]               ovf_a,
    input logic [NUM_PIPES-1:0]               udf_a
);
    import pbm_pkg::*;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BANK_DEPTH);

    a_r10_bus_reset_disables: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (en_a == '0));

    a_r12_no_pipe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && (cpu_addr != RA_PSEL) && (int'(psel) >= NUM_PIPES))
        |=> (cpu_rdata == '0));

    for (genvar i = 0; i < NUM_PIPES; i++) begin : g_chk
        a_r4_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            fill_a[i] <= FULL);

        a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_wr && (cpu_addr == RA_DATA) && (psel == SEL_W'(i)) && en_a[i] &&
             (fill_a[i] == FULL) && !pipe_rst_mask[i] && !bus_rst)
            |=> (ovf_a[i] && (fill_a[i] == FULL)));

        a_r7_pipe_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (pipe_rst_mask[i] && !bus_rst)
            |=> ((fill_a[i] == '0) && !bank_a[i] && !ovf_a[i] && !udf_a[i]));

        a_r7_pipe_reset_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (pipe_rst_mask[i] && !bus_rst)
            |=> ($stable(cfg_a[i]) && $stable(tog_a[i]) && $stable(en_a[i])));

        a_r9_disable_wipes: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_wr && (cpu_addr == RA_EN) && (psel == SEL_W'(i)) && en_a[i] &&
             !cpu_wdata[0] && !pipe_rst_mask[i] && !bus_rst)
            |=> ((cfg_a[i] == '0) && !tog_a[i] && (fill_a[i] == '0) && !en_a[i]));

        a_r11_disabled_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_rd && !cpu_wr && (cpu_addr == RA_DATA) && (psel == SEL_W'(i)) && !en_a[i])
            |=> (cpu_rdata == '0));
    end

endmodule

bind pipe_bank_mgr pbm_chk #(
    .NUM_PIPES(NUM_PIPES), .DATA_W(DATA_W), .CFG_W(CFG_W),
    .BANK_DEPTH(BANK_DEPTH), .SEL_W(SEL_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pipe_rst_mask(pipe_rst_mask), .bus_rst(bus_rst), .psel(psel_q),
    .en_a(en_a), .cfg_a(cfg_a), .tog_a(tog_a), .fill_a(fill_a),
    .bank_a(bank_a), .ovf_a(ovf_a), .udf_a(udf_a)
);

// File: tb/tb_pipe_bank_mgr.sv
`timescale 1ns/100ps
module tb_pipe_bank_mgr;

    localparam int NP = 7;
    localparam int D  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [2:0]    cpu_addr = 3'd0;
    logic [7:0]    cpu_wdata = 8'd0;
    logic [7:0]    cpu_rdata;
    logic [NP-1:0] pipe_rst_mask = '0;
    logic          bus_rst = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pipe_bank_mgr dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pipe_rst_mask(pipe_rst_mask), .bus_rst(bus_rst)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        rd_chk(3'd0, 8'h00, "R1 psel");
        rd_chk(3'd2, 8'h00, "R1 enable");
        rd_chk(3'd3, 8'h00, "R1 cfg");
        rd_chk(3'd6, 8'h00, "R1 status");
        rd_chk(3'd7, 8'h00, "R1 fill");
    endtask

    task automatic t_regmap();
        wr(3'd0, 8'd2);
        wr(3'd2, 8'h01);
        wr(3'd3, 8'hA5);
        wr(3'd4, 8'h01);
        rd_chk(3'd0, 8'd2,  "R2 psel readback");
        rd_chk(3'd2, 8'h01, "R2 enable readback");
        rd_chk(3'd3, 8'hA5, "R2 cfg readback");
        rd_chk(3'd4, 8'h01, "R2 toggle readback");
        rd_chk(3'd5, 8'h00, "R2 release reads zero");
    endtask

    task automatic t_data_order();
        wr(3'd1, 8'h11); wr(3'd1, 8'h22); wr(3'd1, 8'h33);
        rd_chk(3'd7, 8'd3,  "R3 fill after three writes");
        rd_chk(3'd1, 8'h11, "R3 first byte");
        rd_chk(3'd1, 8'h22, "R3 second byte");
        rd_chk(3'd1, 8'h33, "R3 third byte");
    endtask

    task automatic t_overflow_underflow();
        wr(3'd0, 8'd3);
        wr(3'd2, 8'h01);
        for (int i = 0; i < D; i++) wr(3'd1, 8'h40 + 8'(i));
        rd_chk(3'd6, 8'h00, "R4 no overflow at exact fill");
        wr(3'd1, 8'hEE);
        rd_chk(3'd7, 8'(D), "R4 fill held at depth");
        rd_chk(3'd6, 8'h01, "R4 overflow flag");
        for (int i = 0; i < D; i++) rd_chk(3'd1, 8'h40 + 8'(i), "R4 stored bytes intact");
        rd_chk(3'd1, 8'h00, "R5 empty read returns zero");
        rd_chk(3'd6, 8'h03, "R5 underflow flag");
    endtask

    task automatic t_release();
        wr(3'd0, 8'd2);
        wr(3'd5, 8'h00);
        rd_chk(3'd6, 8'h04, "R6 bank flag after release");
        rd_chk(3'd7, 8'h00, "R6 fill cleared by release");
        wr(3'd1, 8'h44);
        rd_chk(3'd1, 8'h44, "R6 new bank data");
        wr(3'd5, 8'h00);
        rd_chk(3'd6, 8'h00, "R6 bank flag back to 0");
    endtask

    task automatic t_pipe_reset();
        wr(3'd1, 8'h55); wr(3'd5, 8'h00); wr(3'd1, 8'h66);
        @(negedge clk); pipe_rst_mask = NP'(1) << 2;
        @(negedge clk); pipe_rst_mask = '0;
        rd_chk(3'd7, 8'h00, "R7 fill cleared");
        rd_chk(3'd6, 8'h00, "R7 status cleared");
        rd_chk(3'd3, 8'hA5, "R7 cfg kept");
        rd_chk(3'd4, 8'h01, "R7 toggle kept");
        rd_chk(3'd2, 8'h01, "R7 enable kept");
    endtask

    task automatic t_coincident();
        logic [7:0] v;
        @(negedge clk);
        pipe_rst_mask = NP'(1) << 2; cpu_wr = 1'b1; cpu_addr = 3'd1; cpu_wdata = 8'h77;
        @(negedge clk);
        pipe_rst_mask = '0; cpu_wr = 1'b0;
        rd_chk(3'd7, 8'h00, "R8 write dropped under pipe reset");
        @(negedge clk);
        pipe_rst_mask = NP'(1) << 4; cpu_wr = 1'b1; cpu_addr = 3'd1; cpu_wdata = 8'h78;
        @(negedge clk);
        pipe_rst_mask = '0; cpu_wr = 1'b0;
        rd_chk(3'd7, 8'h01, "R8 write kept when other pipe resets");
        @(negedge clk);
        pipe_rst_mask = NP'(1) << 2; cpu_rd = 1'b1; cpu_addr = 3'd1;
        @(negedge clk);
        pipe_rst_mask = '0; cpu_rd = 1'b0;
        v = cpu_rdata;
        chk("R8 read under pipe reset returns zero", v, 8'h00);
        rd_chk(3'd3, 8'hA5, "R8 cfg survives");
    endtask

    task automatic t_disable();
        wr(3'd1, 8'h12);
        wr(3'd2, 8'h00);
        wr(3'd2, 8'h01);
        rd_chk(3'd3, 8'h00, "R9 cfg wiped");
        rd_chk(3'd4, 8'h00, "R9 toggle wiped");
        rd_chk(3'd7, 8'h00, "R9 fill wiped");
    endtask

    task automatic t_disabled_access();
        wr(3'd0, 8'd5);
        wr(3'd1, 8'h99);
        wr(3'd5, 8'h00);
        rd_chk(3'd1, 8'h00, "R11 disabled data read zero");
        rd_chk(3'd7, 8'h00, "R11 disabled fill unchanged");
        rd_chk(3'd6, 8'h00, "R11 disabled status unchanged");
    endtask

    task automatic t_no_pipe();
        wr(3'd0, 8'd7);
        wr(3'd3, 8'h3C);
        wr(3'd2, 8'h01);
        rd_chk(3'd3, 8'h00, "R12 cfg reads zero");
        rd_chk(3'd2, 8'h00, "R12 enable reads zero");
        rd_chk(3'd0, 8'd7,  "R12 psel still readable");
        wr(3'd0, 8'd6);
        rd_chk(3'd3, 8'h00, "R12 last pipe untouched");
        rd_chk(3'd2, 8'h00, "R12 last pipe still disabled");
    endtask

    task automatic t_bus_reset();
        wr(3'd0, 8'd1); wr(3'd2, 8'h01); wr(3'd3, 8'h5A); wr(3'd1, 8'h01);
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
        rd_chk(3'd0, 8'd1,  "R10 psel kept");
        rd_chk(3'd2, 8'h00, "R10 enable cleared");
        rd_chk(3'd3, 8'h00, "R10 cfg cleared");
        rd_chk(3'd7, 8'h00, "R10 fill cleared");
        wr(3'd0, 8'd2);
        rd_chk(3'd2, 8'h00, "R10 other pipe cleared");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_data_order();
        t_overflow_underflow();
        t_release();
        t_pipe_reset();
        t_coincident();
        t_disable();
        t_disabled_access();
        t_no_pipe();
        t_bus_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule